// File: doc/BRIEF.md
# Receive Frame Filter and Auto-Acknowledge Controller

This block follows the receiver of a low-rate wireless PHY. It takes the status of each received frame: whether its PHY header was valid, when the frame ended, the checksum result, the frame type, the ack-request bit and the result of the address comparison. From these it decides three things. First, whether the frame is reported with a frame-end interrupt. Second, whether an address-match interrupt is raised. Third, whether an acknowledgement is sent, and at which symbol period after the frame's last symbol it starts.

Frame types 0 to 3 (beacon, data, ack, command) are standard. Types 4 to 7 are reserved. Reserved frames fall under two controls. The upload control lets them be reported at all. The filter control, which only acts while upload is on, sends them through the same address filtering as data frames. A promiscuous mode reports every frame that had a valid header, whatever its filter and checksum results. The ack delay counts strobes of a one-cycle symbol tick. It is either 12 ticks (the default) or 2 ticks (fast setting). The start of a new frame cancels an ack that is still waiting.

Top module: `rx_frame_ack_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, irq_end, irq_addr, crc_ok and ack_go are all 0.
- R2: With cfg_rsv_upload = 0 and cfg_promisc = 0, a frame with ftype 4..7 raises neither irq_end nor irq_addr, and no ack is started.
- R3: With cfg_rsv_upload = 1 and cfg_rsv_filter = 0, a reserved frame raises irq_end if and only if fcs_ok is 1. It never raises irq_addr and never starts an ack.
- R4: cfg_rsv_filter has no effect while cfg_rsv_upload = 0: reserved frames are still dropped as in R2.
- R5: With cfg_rsv_upload = 1 and cfg_rsv_filter = 1, a reserved frame is treated like a data frame. Its irq_end, irq_addr and ack follow R6, R7 and R12.
- R6: irq_addr pulses in the cycle after frm_end when phr_ok = 1, the frame is filtered like a data frame (a standard type, or a reserved type under R5), and addr_hit = 1.
- R7: An ack is started only when all of these hold: phr_ok = 1, the frame is filtered like a data frame, fcs_ok = 1, addr_hit = 1, ack_req = 1, cfg_ack_off = 0, and ftype is not 2 (ack).
- R8: ack_go is a one-cycle pulse in the cycle after the Nth sym_tick that follows frm_end. N is 12 when cfg_fast_ack = 0 and 2 when it is 1. A tick that arrives in the same cycle as frm_end is not counted.
- R9: With cfg_promisc = 1, every frame with phr_ok = 1 raises irq_end, whatever its type, checksum and address. The rules for irq_addr and for the ack do not change.
- R10: crc_ok takes the value of fcs_ok at each frm_end and holds it until the next frm_end.
- R11: A frm_begin pulse without frm_end, while an ack is waiting, cancels that ack. No ack_go follows.
- R12: Without promiscuous mode, a frame filtered like a data frame raises irq_end only if phr_ok, fcs_ok and addr_hit are all 1. irq_end and irq_addr are one-cycle pulses in the cycle after frm_end.
- R13: A frame ending with phr_ok = 0 raises neither interrupt and starts no ack, in any mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_begin | input | 1 | One-cycle pulse when a new frame starts arriving |
| frm_end | input | 1 | One-cycle pulse at the last symbol of a frame |
| phr_ok | input | 1 | PHY header of the current frame was valid |
| fcs_ok | input | 1 | Checksum of the current frame is valid |
| ftype | input | 3 | Frame type: 0..3 standard (2 = ack), 4..7 reserved |
| ack_req | input | 1 | Ack-request bit of the frame header |
| addr_hit | input | 1 | Frame addresses match this node |
| cfg_rsv_upload | input | 1 | Allow reserved frames to be reported |
| cfg_rsv_filter | input | 1 | Filter reserved frames like data frames (needs upload) |
| cfg_fast_ack | input | 1 | 0: ack after 12 symbols, 1: after 2 symbols |
| cfg_promisc | input | 1 | Report every frame with a valid header |
| cfg_ack_off | input | 1 | Suppress all acknowledgements |
| sym_tick | input | 1 | One-cycle strobe per symbol period |
| irq_end | output | 1 | Frame-end interrupt pulse |
| irq_addr | output | 1 | Address-match interrupt pulse |
| crc_ok | output | 1 | Checksum result of the last frame, held |
| ack_go | output | 1 | Pulse that starts the acknowledgement transmit |

## Verification
The bench checks that the filter control does nothing while upload is off. A design that honoured it on its own would let filtered reserved frames through. It sends frames that fail the checksum, or lack an address match, under promiscuous mode. A design that tied the ack to the reported event would then acknowledge frames the filter rejected. It places a symbol tick in the same cycle as the frame end and counts ticks to the exact ack edge in both delay settings, which catches off-by-one loads of the counter. It also starts a new frame while an ack is pending and confirms that a stale ack is never sent. Received ack frames and frames with a bad header are checked for no response.

// File: rtl/rxf_pkg.sv
// Package: shared types and helpers for the receive frame filter.
// Assumes a 3-bit frame type where values at or above FT_FIRST_RSV are reserved.
package rxf_pkg;

    localparam int TYPE_W = 3;

    typedef logic [TYPE_W-1:0] ftype_t;

    localparam ftype_t FT_BEACON    = 3'd0;
    localparam ftype_t FT_DATA      = 3'd1;
    localparam ftype_t FT_ACK       = 3'd2;
    localparam ftype_t FT_CMD       = 3'd3;
    localparam ftype_t FT_FIRST_RSV = 3'd4;

    // Outcome of one frame, valid while frm_end is high.
    typedef struct packed {
        logic report;    // raise frame-end interrupt
        logic addr_evt;  // raise address-match interrupt
        logic ack_want;  // start the ack delay
    } verdict_t;

    // True when the type falls into the reserved range.
    function automatic logic is_reserved(input ftype_t t);
        return (t >= FT_FIRST_RSV);
    endfunction

endpackage

// File: rtl/rxf_decide.sv
// Module: rxf_decide
// Pure combinational verdict for one frame from its status and the configuration.
// Assumes the inputs are stable while frm_end is high; the result is used only then.
module rxf_decide
    import rxf_pkg::*;
(
    input  logic     phr_ok,
    input  logic     fcs_ok,
    input  ftype_t   ftype,
    input  logic     ack_req,
    input  logic     addr_hit,
    input  logic     cfg_rsv_upload,
    input  logic     cfg_rsv_filter,
    input  logic     cfg_promisc,
    input  logic     cfg_ack_off,
    output verdict_t verdict
);

    logic rsv;
    logic filt_eff;
    logic data_like;
    logic lvl3_pass;
    logic std_report;

    // Classify the frame and work out which filter path it takes.
    always_comb begin
        rsv        = is_reserved(ftype);
        filt_eff   = cfg_rsv_upload & cfg_rsv_filter;
        data_like  = ~rsv | filt_eff;
        lvl3_pass  = fcs_ok & addr_hit;
        std_report = data_like ? lvl3_pass : (cfg_rsv_upload & fcs_ok);
    end

    // Form the three decisions; promiscuous mode only widens reporting.
    always_comb begin
        verdict.report   = phr_ok & (cfg_promisc | std_report);
        verdict.addr_evt = phr_ok & data_like & addr_hit;
        verdict.ack_want = phr_ok & data_like & lvl3_pass & ack_req
                         & ~cfg_ack_off & (ftype != FT_ACK);
    end

endmodule

// File: rtl/rxf_ack_timer.sv
// Module: rxf_ack_timer
// Counts symbol ticks from a frame end and pulses fire after the chosen delay.
// Assumes arm and cancel are single-cycle; arm wins over cancel, both win over a tick.
module rxf_ack_timer #(
    parameter int SLOW_DELAY = 12,
    parameter int FAST_DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic fast,
    input  logic cancel,
    input  logic tick,
    output logic fire
);

    localparam int MAX_DELAY = (SLOW_DELAY > FAST_DELAY) ? SLOW_DELAY : FAST_DELAY;
    localparam int CNT_W     = $clog2(MAX_DELAY + 1);

    logic             pending;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    // Choose the reload value from the delay setting.
    always_comb begin
        load_val = fast ? CNT_W'(FAST_DELAY) : CNT_W'(SLOW_DELAY);
    end

    // Track the pending ack and count down one step per symbol tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            cnt     <= '0;
            fire    <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (arm) begin
                pending <= 1'b1;
                cnt     <= load_val;
            end else if (cancel) begin
                pending <= 1'b0;
                cnt     <= '0;
            end else if (pending && tick) begin
                if (cnt <= CNT_W'(1)) begin
                    pending <= 1'b0;
                    cnt     <= '0;
                    fire    <= 1'b1;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/rx_frame_ack_ctrl.sv
// Module: rx_frame_ack_ctrl
// Top of the receive frame filter: registers interrupts and checksum status at
// frame end and drives the delayed ack start. Assumes frm_end and frm_begin are
// one-cycle pulses and that frame status inputs are valid while frm_end is high.
module rx_frame_ack_ctrl
    import rxf_pkg::*;
#(
    parameter int SLOW_DELAY = 12,
    parameter int FAST_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_begin,
    input  logic              frm_end,
    input  logic              phr_ok,
    input  logic              fcs_ok,
    input  logic [TYPE_W-1:0] ftype,
    input  logic              ack_req,
    input  logic              addr_hit,
    input  logic              cfg_rsv_upload,
    input  logic              cfg_rsv_filter,
    input  logic              cfg_fast_ack,
    input  logic              cfg_promisc,
    input  logic              cfg_ack_off,
    input  logic              sym_tick,
    output logic              irq_end,
    output logic              irq_addr,
    output logic              crc_ok,
    output logic              ack_go
);

    verdict_t verdict;
    logic     arm;
    logic     cancel;

    rxf_decide u_decide (
        .phr_ok         (phr_ok),
        .fcs_ok         (fcs_ok),
        .ftype          (ftype),
        .ack_req        (ack_req),
        .addr_hit       (addr_hit),
        .cfg_rsv_upload (cfg_rsv_upload),
        .cfg_rsv_filter (cfg_rsv_filter),
        .cfg_promisc    (cfg_promisc),
        .cfg_ack_off    (cfg_ack_off),
        .verdict        (verdict)
    );

    // Arm the timer at a qualifying frame end; a bare frame start cancels it.
    always_comb begin
        arm    = frm_end & verdict.ack_want;
        cancel = frm_begin & ~frm_end;
    end

    rxf_ack_timer #(
        .SLOW_DELAY (SLOW_DELAY),
        .FAST_DELAY (FAST_DELAY)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm),
        .fast   (cfg_fast_ack),
        .cancel (cancel),
        .tick   (sym_tick),
        .fire   (ack_go)
    );

    // Register the interrupt pulses and the held checksum flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_end  <= 1'b0;
            irq_addr <= 1'b0;
            crc_ok   <= 1'b0;
        end else begin
            irq_end  <= frm_end & verdict.report;
            irq_addr <= frm_end & verdict.addr_evt;
            if (frm_end) begin
                crc_ok <= fcs_ok;
            end
        end
    end

endmodule

// File: rtl/rx_frame_ack_ctrl_chk.sv
// Module: rx_frame_ack_ctrl_chk
// Property checker bound to rx_frame_ack_ctrl; observes ports only.
module rx_frame_ack_ctrl_chk
    import rxf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frm_begin,
    input logic              frm_end,
    input logic              phr_ok,
    input logic              fcs_ok,
    input logic [TYPE_W-1:0] ftype,
    input logic              cfg_rsv_upload,
    input logic              cfg_promisc,
    input logic              sym_tick,
    input logic              irq_end,
    input logic              irq_addr,
    input logic              crc_ok,
    input logic              ack_go
);

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_end |=> $stable(crc_ok)); // R10
    AST_CRC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        frm_end |=> (crc_ok == $past(fcs_ok))); // R10
    AST_END_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_end |-> $past(frm_end)); // R12
    AST_ADDR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_addr |-> $past(frm_end)); // R6
    AST_ACK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ack_go |-> $past(sym_tick)); // R8
    AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_begin && !frm_end) |=> !ack_go); // R11
    AST_RSV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_end && is_reserved(ftype) && !cfg_rsv_upload && !cfg_promisc)
        |=> (!irq_end && !irq_addr)); // R2
    AST_PROMISC: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_end && phr_ok && cfg_promisc) |=> irq_end); // R9
    AST_NO_PHR: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_end && !phr_ok) |=> (!irq_end && !irq_addr)); // R13

endmodule

bind rx_frame_ack_ctrl rx_frame_ack_ctrl_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .frm_begin      (frm_begin),
    .frm_end        (frm_end),
    .phr_ok         (phr_ok),
    .fcs_ok         (fcs_ok),
    .ftype          (ftype),
    .cfg_rsv_upload (cfg_rsv_upload),
    .cfg_promisc    (cfg_promisc),
    .sym_tick       (sym_tick),
    .irq_end        (irq_end),
    .irq_addr       (irq_addr),
    .crc_ok         (crc_ok),
    .ack_go         (ack_go)
);

// File: tb/rx_frame_ack_ctrl_tb_top.sv
// Bench for rx_frame_ack_ctrl: vector table walked by one loop, then directed cases.
module rx_frame_ack_ctrl_tb_top;

    localparam int SLOW = 12;
    localparam int FAST = 2;

    typedef struct packed {
        logic [3:0] tag;
        logic       upl, flt, fast, prom, aoff, phr, fcs;
        logic [2:0] typ;
        logic       areq, hit, e_end, e_addr, e_ack;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        // tag   upl   flt   fast  prom  aoff  phr   fcs   typ   areq  hit   end   addr  ack
        '{4'd7,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R7 R8 data slow
        '{4'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R8 fast
        '{4'd6,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R6 bad fcs, addr ok
        '{4'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R12 no addr
        '{4'd7,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 no request
        '{4'd7,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 ack off
        '{4'd7,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 ack frame
        '{4'd12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R12 command
        '{4'd2,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 dropped
        '{4'd4,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 filter ignored
        '{4'd3,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 fcs only
        '{4'd3,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 bad fcs
        '{4'd5,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R5 like data
        '{4'd5,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 no addr
        '{4'd9,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R9 fails, reported
        '{4'd9,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R9 reserved
        '{4'd9,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R9 ack kept
        '{4'd13, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R13 promisc
        '{4'd13, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}  // R13 normal
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_begin = 1'b0, frm_end = 1'b0, phr_ok = 1'b0, fcs_ok = 1'b0;
    logic [2:0] ftype = 3'd0;
    logic       ack_req = 1'b0, addr_hit = 1'b0;
    logic       cfg_rsv_upload = 1'b0, cfg_rsv_filter = 1'b0, cfg_fast_ack = 1'b0;
    logic       cfg_promisc = 1'b0, cfg_ack_off = 1'b0, sym_tick = 1'b0;
    logic       irq_end, irq_addr, crc_ok, ack_go;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_frame_ack_ctrl #(.SLOW_DELAY(SLOW), .FAST_DELAY(FAST)) dut_i (
        .clk (clk), .rst_n (rst_n), .frm_begin (frm_begin), .frm_end (frm_end),
        .phr_ok (phr_ok), .fcs_ok (fcs_ok), .ftype (ftype), .ack_req (ack_req),
        .addr_hit (addr_hit), .cfg_rsv_upload (cfg_rsv_upload),
        .cfg_rsv_filter (cfg_rsv_filter), .cfg_fast_ack (cfg_fast_ack),
        .cfg_promisc (cfg_promisc), .cfg_ack_off (cfg_ack_off), .sym_tick (sym_tick),
        .irq_end (irq_end), .irq_addr (irq_addr), .crc_ok (crc_ok), .ack_go (ack_go)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic setup(input vec_t v);
        cfg_rsv_upload = v.upl;  cfg_rsv_filter = v.flt; cfg_fast_ack = v.fast;
        cfg_promisc    = v.prom; cfg_ack_off    = v.aoff;
        phr_ok = v.phr; fcs_ok = v.fcs; ftype = v.typ; ack_req = v.areq; addr_hit = v.hit;
    endtask

    // Starts at a negedge; drives n ticks with a gap cycle after each.
    task automatic ticks(input int n, output int fire, output int pulses);
        fire = 0;
        pulses = 0;
        for (int i = 1; i <= n; i++) begin
            sym_tick = 1'b1;
            @(negedge clk);
            sym_tick = 1'b0;
            if (ack_go) begin
                pulses++;
                if (fire == 0) fire = i;
            end
            @(negedge clk);
            if (ack_go) pulses++;
        end
    endtask

    task automatic run_vec(input vec_t v);
        string r;
        int fire, pulses;
        r = $sformatf("R%0d", v.tag);
        @(negedge clk);
        setup(v);
        frm_begin = 1'b1;
        @(negedge clk);
        frm_begin = 1'b0;
        frm_end = 1'b1;
        @(negedge clk);
        frm_end = 1'b0;
        chk(r, "irq_end", int'(irq_end), int'(v.e_end));
        chk(r, "irq_addr", int'(irq_addr), int'(v.e_addr));
        chk("R10", "crc_ok", int'(crc_ok), int'(v.fcs));
        chk(r, "early ack_go", int'(ack_go), 0);
        @(negedge clk);
        chk("R12", "irq_end width", int'(irq_end), 0);
        chk("R12", "irq_addr width", int'(irq_addr), 0);
        ticks(SLOW + 2, fire, pulses);
        chk(r, "ack tick index", fire, v.e_ack ? (v.fast ? FAST : SLOW) : 0);
        chk(r, "ack pulse count", pulses, v.e_ack ? 1 : 0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        int fire, pulses;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "irq_end in reset", int'(irq_end), 0);
        chk("R1", "irq_addr in reset", int'(irq_addr), 0);
        chk("R1", "crc_ok in reset", int'(crc_ok), 0);
        chk("R1", "ack_go in reset", int'(ack_go), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after release", int'({irq_end, irq_addr, crc_ok, ack_go}), 0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R8: a tick coincident with frm_end is not counted
        setup(VECS[0]);
        frm_end = 1'b1;
        sym_tick = 1'b1;
        @(negedge clk);
        frm_end = 1'b0;
        sym_tick = 1'b0;
        ticks(SLOW + 2, fire, pulses);
        chk("R8", "coincident tick index", fire, SLOW);
        chk("R8", "coincident tick pulses", pulses, 1);

        // R11: a new frame cancels the waiting ack
        setup(VECS[0]);
        frm_end = 1'b1;
        @(negedge clk);
        frm_end = 1'b0;
        ticks(5, fire, pulses);
        frm_begin = 1'b1;
        @(negedge clk);
        frm_begin = 1'b0;
        ticks(SLOW + 2, fire, pulses);
        chk("R11", "ack after cancel", pulses, 0);

        // R10: crc_ok holds between frame ends
        setup(VECS[0]);
        frm_end = 1'b1;
        @(negedge clk);
        frm_end = 1'b0;
        fcs_ok = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10", "crc_ok held high", int'(crc_ok), 1);
        frm_begin = 1'b1;
        @(negedge clk);
        frm_begin = 1'b0;
        frm_end = 1'b1;
        @(negedge clk);
        frm_end = 1'b0;
        fcs_ok = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10", "crc_ok held low", int'(crc_ok), 0);

        done = 1'b1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

endmodule